// File: doc/BRIEF.md
# Serial-Bus Slave with Auto-Incrementing Register Pointer

This block is the bus-facing front end of a small timekeeping register bank. It listens on a two-wire serial bus as a slave with the 7-bit address 1101000, so its write address byte is D0h and its read address byte is D1h. It reaches an external eight-entry byte register file through a 3-bit pointer. In write order the entries are seconds, minutes, hours, day of week, day of month, month, year and control. The register file sits outside the block and answers on a combinational read port.

In a write transfer, the byte after the address sets the pointer. Each later byte is written at the pointer with a one-cycle strobe, and the pointer then steps forward, wrapping from 7 to 0. A read transfer begins either after a word-address write and a repeated start, or straight away from wherever the pointer was left. A byte is sent from the pointer, and the pointer moves on only when the master acknowledges that byte. The block keeps its own copy of bit 7 of the control entry and drives a separate open-drain level pin from it. While a read of a time entry (0 to 6) is running, it raises a flag so the time keeper can hold back its updates. SCL and SDA are sampled into a system clock that runs at least eight times the bus clock. Clock stretching and general call are not supported.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After reset, sda_oe is 0, out_low is 0 (the held control bit 7 resets to 1), rd_active is 0, and the pointer is 0.
- R2: An address byte whose upper seven bits equal 1101000 is acknowledged: SDA is held low through the ninth clock. Any other address byte gets no acknowledge, and nothing is written until the next start.
- R3: In a write transfer, the first byte after the address is acknowledged, and its low three bits load the pointer.
- R4: Every later byte in a write transfer is acknowledged and produces exactly one reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then increments, wrapping from 7 to 0.
- R5: After a word-address write and a repeated start with address byte D1h, the block sends the entry at the pointer, most significant bit first.
- R6: During a read, the pointer increments only when the master drives SDA low in the acknowledge slot. On a not-acknowledge, the block releases SDA and sends nothing more until the next start.
- R7: A read transfer with no word-address write before it begins at the pointer value left by the previous transfer.
- R8: A stop or start at any bit position abandons the current byte without writing it. The pointer keeps its value.
- R9: Writing address 7 stores reg_wdata bit 7. out_low is 1 (pin pulled low) exactly when that stored bit is 0.
- R10: rd_active rises at the end of a read address acknowledge when the pointer is in 0..6. It falls on a stop, a start or a master not-acknowledge, and it is never high together with reg_we.
- R11: sda_oe changes only while the sampled SCL is low, except when it is released because of a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 3 | Register file address (the pointer) |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle strobe when a byte is taken for sending |
| reg_rdata | input | 8 | Register file data at reg_addr |
| rd_active | output | 1 | A read of a time entry is in progress |
| out_low | output | 1 | 1 pulls the level pin low |

## Verification
The bench targets the pointer's rules at their edges. A design that advances the pointer on a not-acknowledge makes the pointer-only read return the wrong entry. A design that forgets to wrap writes a three-byte burst starting at 6 to address 8 instead of 0. A stop in the middle of a byte checks that a partial byte is never written, and a foreign address checks that there is neither an acknowledge nor a write. The control-bit pin and the read flag are checked at address 7, where the flag must stay low. Every write strobe is matched against a queue of expected writes.

// File: rtl/i2c_rp_pkg.sv
// Shared types for the register-pointer serial slave.
// Assumes one byte lane of eight bits on the bus.
package i2c_rp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,    // not addressed, wait for start
        ST_RX,      // shifting in a byte from the master
        ST_RX_ACK,  // slave drives acknowledge slot
        ST_TX,      // shifting out a byte to the master
        ST_TX_ACK   // master's acknowledge slot
    } bus_st_t;

    typedef enum logic [1:0] {
        BK_DEV,     // address byte with direction bit
        BK_WORD,    // word address for the pointer
        BK_DATA     // payload byte
    } byte_kind_t;
endpackage

// File: rtl/i2c_bus_sync.sv
// Brings SCL and SDA into the system clock domain and flags SCL edges
// and start/stop conditions. Assumes STAGES >= 2 and that the system
// clock is fast enough that each bus phase spans several samples.
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode from settled samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        bus_start = scl_s & scl_q & sda_q & ~sda_s;
        bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_ptr_reg.sv
// Register pointer with load/increment, and the held copy of the
// control entry's top bit. The control entry is the highest address.
// Assumes load and inc are never requested together.
module i2c_ptr_reg #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    input  logic          wr_en,
    input  logic          wr_msb,
    output logic [AW-1:0] ptr,
    output logic          ctl_msb
);
    localparam logic [AW-1:0] CTL_ADDR = '1;

    // Pointer update: load has priority, increment wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Capture bit 7 whenever the control entry is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_msb <= 1'b1;
        end else if (wr_en && ptr == CTL_ADDR) begin
            ctl_msb <= wr_msb;
        end
    end
endmodule

// File: rtl/i2c_regptr_slave.sv
// Serial-bus slave giving byte access to an external register file
// through an auto-incrementing pointer. Assumes the register file
// answers reg_rdata combinationally from reg_addr, and that the
// system clock runs at least 8x SCL. No clock stretching.
module i2c_regptr_slave
    import i2c_rp_pkg::*;
#(
    parameter int          ADDR_W      = 3,
    parameter logic [6:0]  DEV_ADDR    = 7'h68,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [7:0]        reg_rdata,
    output logic              rd_active,
    output logic              out_low
);
    localparam int              CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [ADDR_W-1:0] CTL_ADDR = '1;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    bus_st_t          st;
    byte_kind_t       kind;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       shreg;
    logic             byte_done;
    logic             rw;
    logic             mack;
    logic             sda_oe_q;
    logic             rd_act_q;

    logic              ptr_load, ptr_inc, ctl_msb;
    logic [ADDR_W-1:0] ptr;
    logic              rx_end, tx_ack_rise;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_ptr_reg #(.AW(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load),
        .load_val(shreg[ADDR_W-1:0]), .inc(ptr_inc),
        .wr_en(reg_we), .wr_msb(reg_wdata[7]),
        .ptr(ptr), .ctl_msb(ctl_msb)
    );

    // Strobes toward the register file and pointer, decoded per cycle.
    always_comb begin
        rx_end      = (st == ST_RX) && scl_fall && byte_done && !bus_start && !bus_stop;
        tx_ack_rise = (st == ST_TX_ACK) && scl_rise && !bus_start && !bus_stop;
        reg_we      = rx_end && (kind == BK_DATA);
        ptr_load    = rx_end && (kind == BK_WORD);
        ptr_inc     = reg_we || (tx_ack_rise && !sda_s);
        reg_re      = !bus_start && !bus_stop && scl_fall &&
                      (((st == ST_RX_ACK) && (kind == BK_DEV) && rw) ||
                       ((st == ST_TX_ACK) && mack));
        reg_addr    = ptr;
        reg_wdata   = shreg;
        sda_oe      = sda_oe_q;
        rd_active   = rd_act_q;
        out_low     = ~ctl_msb;
    end

    // Transfer sequencer: bit counting, acknowledge and byte shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind      <= BK_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            sda_oe_q  <= 1'b0;
            rd_act_q  <= 1'b0;
        end else if (bus_stop) begin
            st       <= ST_IDLE;
            sda_oe_q <= 1'b0;
            rd_act_q <= 1'b0;
        end else if (bus_start) begin
            st        <= ST_RX;
            kind      <= BK_DEV;
            bitcnt    <= '0;
            byte_done <= 1'b0;
            sda_oe_q  <= 1'b0;
            rd_act_q  <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (scl_rise && !byte_done) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) byte_done <= 1'b1;
                    end else if (scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        bitcnt    <= '0;
                        if (kind == BK_DEV && shreg[7:1] != DEV_ADDR) begin
                            st <= ST_IDLE;
                        end else begin
                            st       <= ST_RX_ACK;
                            sda_oe_q <= 1'b1;
                            if (kind == BK_DEV) rw <= shreg[0];
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (kind == BK_DEV && rw) begin
                            st       <= ST_TX;
                            shreg    <= reg_rdata;
                            sda_oe_q <= ~reg_rdata[7];
                            rd_act_q <= (ptr != CTL_ADDR);
                        end else begin
                            st       <= ST_RX;
                            sda_oe_q <= 1'b0;
                            kind     <= (kind == BK_DEV) ? BK_WORD : BK_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == LAST_BIT) begin
                            sda_oe_q <= 1'b0;
                            st       <= ST_TX_ACK;
                        end else begin
                            bitcnt   <= bitcnt + 1'b1;
                            shreg    <= {shreg[6:0], 1'b0};
                            sda_oe_q <= ~shreg[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            st       <= ST_TX;
                            bitcnt   <= '0;
                            shreg    <= reg_rdata;
                            sda_oe_q <= ~reg_rdata[7];
                        end else begin
                            st       <= ST_IDLE;
                            rd_act_q <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!scl_s || $past(bus_start || bus_stop))); // R11
    AST_ACK_SLOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RX_ACK) |-> sda_oe); // R2
    AST_TXACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX_ACK) |-> !sda_oe); // R6
    AST_WR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + 1'b1)); // R4
    AST_NO_WE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !rd_active); // R10
    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CTL_ADDR) |=> (out_low == !$past(reg_wdata[7]))); // R9
endmodule

// File: tb/sim_i2c_regptr_slave.sv
module sim_i2c_regptr_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 5;   // quarter SCL period in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic sda_oe, reg_we, reg_re, rd_active, out_low;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] mem [8];
    int exp_mem [8];
    int exp_ptr = 0;
    int exp_wq [$];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_regptr_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .rd_active(rd_active), .out_low(out_low)
    );

    // Behavioural register file answering the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = mem[reg_addr];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Every write strobe is compared with the model's expected writes (R4).
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_wq.size() == 0) chk("R4 unexpected write", {reg_addr, reg_wdata}, -1);
            else chk("R4 write addr/data", {reg_addr, reg_wdata}, exp_wq.pop_front());
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl = 1'b1; tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(bit b);
        m_sda_low = !b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output bit b);
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!give_ack);
    endtask

    // Write transfer of n (1..3) bytes starting at addr.
    task automatic wr_txn(int addr, int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
        send_byte(8'(addr), ack); chk("R3 word address ack", ack, 1);
        exp_ptr = addr % 8;
        for (int k = 0; k < n; k++) begin
            d = (k == 0) ? b0 : (k == 1) ? b1 : b2;
            exp_wq.push_back({exp_ptr[2:0], d});
            exp_mem[exp_ptr] = d;
            send_byte(d, ack); chk("R4 data ack", ack, 1);
            exp_ptr = (exp_ptr + 1) % 8;
        end
        bus_stop();
    endtask

    // Read transfer of n bytes, optionally setting the pointer first.
    task automatic rd_txn(bit set_addr, int addr, int n, string tag);
        bit ack;
        logic [7:0] d;
        bus_start();
        if (set_addr) begin
            send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
            send_byte(8'(addr), ack); chk("R3 word address ack", ack, 1);
            exp_ptr = addr % 8;
            bus_rstart();
        end
        send_byte(8'hD1, ack); chk("R2 read address ack", ack, 1);
        chk("R10 rd_active after read address", rd_active, (exp_ptr != 7) ? 1 : 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k < n - 1);
            chk(tag, d, exp_mem[exp_ptr]);
            if (k < n - 1) exp_ptr = (exp_ptr + 1) % 8;
        end
        chk("R6 SDA released after nack", sda_oe, 0);
        chk("R10 rd_active low after nack", rd_active, 0);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        for (int i = 0; i < 8; i++) exp_mem[i] = 0;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        chk("R1 sda_oe at reset", sda_oe, 0);
        chk("R1 out_low at reset", out_low, 0);
        chk("R1 rd_active at reset", rd_active, 0);
        chk("R1 pointer at reset", reg_addr, 0);

        wr_txn(2, 3, 8'h11, 8'h22, 8'h33);
        rd_txn(1, 2, 3, "R5 combined read data");
        chk("R6 pointer held on nack", reg_addr, 4);
        rd_txn(0, 0, 1, "R7 pointer-only read data");

        // Foreign address: no acknowledge, no write (R2).
        bus_start();
        send_byte(8'hA0, ack); chk("R2 foreign address nack", ack, 0);
        send_byte(8'h05, ack); chk("R2 foreign byte nack", ack, 0);
        bus_stop();
        chk("R2 pointer untouched", reg_addr, 4);

        // Burst across the top of the map wraps to 0 and drives OUT (R4, R9).
        wr_txn(6, 3, 8'h5A, 8'h00, 8'hC3);
        chk("R9 out_low with bit7 clear", out_low, 1);
        chk("R4 wrap pointer", reg_addr, 1);
        rd_txn(1, 0, 1, "R4 wrapped entry read");
        wr_txn(7, 1, 8'h80, 8'h00, 8'h00);
        chk("R9 out_low with bit7 set", out_low, 0);
        rd_txn(1, 7, 1, "R10 control entry read");

        // Stop right after the word address keeps the new pointer (R8).
        bus_start();
        send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
        send_byte(8'h05, ack); chk("R3 word address ack", ack, 1);
        exp_ptr = 5;
        bus_stop();
        rd_txn(0, 0, 1, "R8 read after early stop");

        // Stop in the middle of a data byte writes nothing (R8).
        bus_start();
        send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
        send_byte(8'h01, ack); chk("R3 word address ack", ack, 1);
        exp_ptr = 1;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk("R8 pointer after partial byte", reg_addr, 1);
        rd_txn(0, 0, 1, "R8 entry after partial byte");

        chk("R4 all expected writes seen", exp_wq.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule